// File: doc/BRIEF.md
# E1 Transmit Timeslot Substitution

This block sits in the transmit path of an E1 framer. It takes the serial backplane stream one bit per strobe, tracks the position of each bit within the 256-bit frame from a frame-sync pulse, and produces the outgoing serial frame. Each of the 32 timeslots has one select bit in a 32-bit channel mask. A clear bit lets the backplane data through unchanged. A set bit replaces the timeslot, and a mode bit picks the replacement source. With the mode bit at 0 the source is one 8-bit idle pattern shared by every timeslot. With the mode bit at 1 the source is the matching timeslot of the receive-side serial stream, which loops that channel back toward the line.

The receive stream must be aligned to the transmit frame. It shares the bit strobe and frame sync with the backplane input. The stream side has no back-pressure, because a TDM line cannot stall. `bit_stb` acts as the valid qualifier of both inputs, and `tx_valid` is the matching qualifier of the output. A byte-wide register port sets the mask, the idle pattern and the mode bit.

Top module: `e1_tx_chan_insert`

## Requirements
- R1: A strobe with `fsync` high carries bit 0 of the frame. Each later strobe advances the position by one, and the position wraps from 255 to 0. The position divided by 8 is the timeslot (channel n is timeslot n-1), and the position modulo 8 is the bit within it. Bit 0 of a timeslot is its most significant bit. An `fsync` that arrives early restarts the frame at once.
- R2: The mask is written at addresses 0x26 to 0x29. Address 0x26 holds channels 1 to 8, 0x27 holds 9 to 16, 0x28 holds 17 to 24 and 0x29 holds 25 to 32. Bit 0 of each register maps to the lowest channel of its group, and bit 7 to the highest.
- R3: Address 0x2A holds the idle pattern and address 0x2B bit 0 holds the mode bit. All of these registers read back through `reg_rdata` in the same cycle. Bits 7 to 1 of 0x2B, and every unmapped address, read as 0.
- R4: With the mode bit at 0 and the channel's mask bit at 1, the channel carries the idle pattern, most significant bit first.
- R5: With the channel's mask bit at 0, the output bit equals the backplane bit in either mode.
- R6: With the mode bit at 1 and the channel's mask bit at 1, the output bit equals the receive-stream bit of the same strobe.
- R7: Any set of channels, up to all 32, may be replaced at once, and the replacement is the same for all of them.
- R8: `tx_data` and `tx_valid` update on the clock edge that samples a strobe, which gives a fixed one-cycle latency. `tx_valid` is high only in the cycle after a strobe, and `tx_data` holds its value between strobes.
- R9: The mask bit, mode bit and idle pattern are taken at bit 0 of each timeslot. A write during a timeslot first affects the next timeslot, so no channel leaves half replaced.
- R10: After reset all registers read 0, which means pass-through, and `tx_valid` and `tx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | Valid strobe for one bit of both serial inputs |
| fsync | input | 1 | Frame start, qualified by `bit_stb` |
| bp_data | input | 1 | Backplane serial data |
| rx_data | input | 1 | Receive-side serial data, frame aligned |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| tx_data | output | 1 | Outgoing serial data |
| tx_valid | output | 1 | Qualifies `tx_data`, one cycle after each strobe |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of a timeslot, in the same cycle as a strobe. Only the bits still to come in that timeslot show whether the old setting was kept. The stimulus places register writes at chosen frame positions, including a mask change inside channel 5 and a mode flip inside a looped-back frame. A frame cut short by an early `fsync`, and random gaps between strobes, test the position counter and the hold behaviour of the output.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;
  localparam int SLOTS_DEF     = 32;
  localparam int SLOT_BITS_DEF = 8;
  localparam int ADDR_W_DEF    = 8;
  localparam int MASK_BASE_DEF = 'h26;
  localparam int CODE_ADDR_DEF = 'h2A;
  localparam int MODE_ADDR_DEF = 'h2B;
endpackage

// File: rtl/e1_slot_timer.sv
// Frame position tracker; SLOTS and SLOT_BITS must be powers of two.
module e1_slot_timer #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int BIT_W      = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              fsync,
  output logic [SLOT_W-1:0] slot_now,
  output logic [BIT_W-1:0]  bitn_now,
  output logic              boundary
);
  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] pos_now;

  // Position of the bit on the current strobe
  always_comb begin
    if (fsync)                                pos_now = '0;
    else if (cnt_q == POS_W'(FRAME_BITS - 1)) pos_now = '0;
    else                                      pos_now = cnt_q + 1'b1;
  end

  assign slot_now = pos_now[POS_W-1:BIT_W];
  assign bitn_now = pos_now[BIT_W-1:0];
  assign boundary = (bitn_now == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= POS_W'(FRAME_BITS - 1);
    else if (bit_stb) cnt_q <= pos_now;
  end
endmodule

// File: rtl/e1_chan_regs.sv
module e1_chan_regs #(
  parameter int SLOTS     = 32,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int MASK_BASE = 'h26,
  parameter int CODE_ADDR = 'h2A,
  parameter int MODE_ADDR = 'h2B,
  localparam int MASK_REGS = SLOTS / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [SLOTS-1:0]  mask,
  output logic [DATA_W-1:0] code,
  output logic              mode
);
  logic [DATA_W-1:0] mask_r [MASK_REGS];
  logic [DATA_W-1:0] code_r;
  logic              mode_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MASK_REGS; i++) mask_r[i] <= '0;
      code_r <= '0;
      mode_r <= 1'b0;
    end else if (reg_we) begin
      for (int i = 0; i < MASK_REGS; i++)
        if (reg_addr == ADDR_W'(MASK_BASE + i)) mask_r[i] <= reg_wdata;
      if (reg_addr == ADDR_W'(CODE_ADDR)) code_r <= reg_wdata;
      if (reg_addr == ADDR_W'(MODE_ADDR)) mode_r <= reg_wdata[0];
    end
  end

  // Channel n of group g sits at bit g*DATA_W + n of the flat mask
  for (genvar g = 0; g < MASK_REGS; g++) begin : g_flat
    assign mask[g*DATA_W +: DATA_W] = mask_r[g];
  end

  assign code = code_r;
  assign mode = mode_r;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < MASK_REGS; i++)
      if (reg_addr == ADDR_W'(MASK_BASE + i)) reg_rdata = mask_r[i];
    if (reg_addr == ADDR_W'(CODE_ADDR)) reg_rdata = code_r;
    if (reg_addr == ADDR_W'(MODE_ADDR)) reg_rdata = {{(DATA_W-1){1'b0}}, mode_r};
  end
endmodule

// File: rtl/e1_chan_mux.sv
module e1_chan_mux #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb,
  input  logic                 boundary,
  input  logic [SLOT_W-1:0]    slot_now,
  input  logic [BIT_W-1:0]     bitn_now,
  input  logic [SLOTS-1:0]     mask,
  input  logic [SLOT_BITS-1:0] code,
  input  logic                 mode,
  input  logic                 bp_data,
  input  logic                 rx_data,
  output logic                 sel_now,
  output logic                 loop_now,
  output logic                 tx_data,
  output logic                 tx_valid
);
  logic                 lat_sel, lat_mode;
  logic [SLOT_BITS-1:0] lat_code, code_now;
  logic                 idle_bit, nxt_bit;

  // At bit 0 the live settings apply, and later bits use the copy taken there
  assign sel_now  = boundary ? mask[slot_now] : lat_sel;
  assign loop_now = boundary ? mode : lat_mode;
  assign code_now = boundary ? code : lat_code;
  assign idle_bit = code_now[BIT_W'(SLOT_BITS - 1) - bitn_now];

  always_comb begin
    if (!sel_now)      nxt_bit = bp_data;
    else if (loop_now) nxt_bit = rx_data;
    else               nxt_bit = idle_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data  <= 1'b0;
      tx_valid <= 1'b0;
      lat_sel  <= 1'b0;
      lat_mode <= 1'b0;
      lat_code <= '0;
    end else begin
      tx_valid <= bit_stb;
      if (bit_stb) begin
        tx_data <= nxt_bit;
        if (boundary) begin
          lat_sel  <= sel_now;
          lat_mode <= loop_now;
          lat_code <= code_now;
        end
      end
    end
  end
endmodule

// File: rtl/e1_tx_chan_insert.sv
module e1_tx_chan_insert
  import e1_tx_pkg::*;
#(
  parameter int SLOTS     = SLOTS_DEF,
  parameter int SLOT_BITS = SLOT_BITS_DEF,
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int MASK_BASE = MASK_BASE_DEF,
  parameter int CODE_ADDR = CODE_ADDR_DEF,
  parameter int MODE_ADDR = MODE_ADDR_DEF,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb,
  input  logic                 fsync,
  input  logic                 bp_data,
  input  logic                 rx_data,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [SLOT_BITS-1:0] reg_wdata,
  output logic [SLOT_BITS-1:0] reg_rdata,
  output logic                 tx_data,
  output logic                 tx_valid
);
  logic [SLOT_W-1:0]    slot_now;
  logic [BIT_W-1:0]     bitn_now;
  logic                 boundary;
  logic [SLOTS-1:0]     mask;
  logic [SLOT_BITS-1:0] code;
  logic                 mode;
  logic                 sel_now, loop_now;

  e1_slot_timer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fsync(fsync),
    .slot_now(slot_now), .bitn_now(bitn_now), .boundary(boundary)
  );

  e1_chan_regs #(
    .SLOTS(SLOTS), .DATA_W(SLOT_BITS), .ADDR_W(ADDR_W),
    .MASK_BASE(MASK_BASE), .CODE_ADDR(CODE_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mask(mask), .code(code), .mode(mode)
  );

  e1_chan_mux #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_mux (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .boundary(boundary),
    .slot_now(slot_now), .bitn_now(bitn_now), .mask(mask), .code(code),
    .mode(mode), .bp_data(bp_data), .rx_data(rx_data),
    .sel_now(sel_now), .loop_now(loop_now),
    .tx_data(tx_data), .tx_valid(tx_valid)
  );
endmodule

// File: rtl/e1_tx_chan_chk.sv
module e1_tx_chan_chk
  import e1_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic       bp_data,
  input logic       rx_data,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       tx_data,
  input logic       tx_valid,
  input logic       sel_now,
  input logic       loop_now
);
  logic rw_addr, mapped;
  assign rw_addr = (reg_addr >= 8'(MASK_BASE_DEF)) && (reg_addr <= 8'(CODE_ADDR_DEF));
  assign mapped  = (reg_addr >= 8'(MASK_BASE_DEF)) && (reg_addr <= 8'(MODE_ADDR_DEF));

  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> tx_valid);
  a_r8_valid_only_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> !tx_valid);
  a_r8_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(tx_data));
  a_r5_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !sel_now) |=> (tx_data == $past(bp_data)));
  a_r6_loopback: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && sel_now && loop_now) |=> (tx_data == $past(rx_data)));
  a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && rw_addr) |=> ((reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata))));
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == 8'h00));
endmodule

bind e1_tx_chan_insert e1_tx_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bp_data(bp_data),
  .rx_data(rx_data), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
  .tx_valid(tx_valid), .sel_now(sel_now), .loop_now(loop_now)
);

// File: tb/e1_tx_chan_insert_bench.sv
module e1_tx_chan_insert_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0, fsync = 1'b0, bp_data = 1'b0, rx_data = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx_data, tx_valid;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  typedef struct { logic val; string req; } exp_t;
  exp_t sb_q[$];

  // Bench view of the registers and of the per-timeslot copy
  logic [31:0] sh_mask = '0;
  logic [7:0]  sh_code = '0;
  logic        sh_mode = 1'b0;
  logic        lat_sel = 1'b0, lat_mode = 1'b0;
  logic [7:0]  lat_code = '0;
  bit          mid_write = 1'b0;

  always #2.5 clk = ~clk;

  e1_tx_chan_insert u_e1_tx_chan_insert (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fsync(fsync),
    .bp_data(bp_data), .rx_data(rx_data), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid)
  );

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void shadow_write(logic [7:0] a, logic [7:0] d);
    if (a >= 8'h26 && a <= 8'h29) sh_mask[(a - 8'h26) * 8 +: 8] = d;
    if (a == 8'h2A) sh_code = d;
    if (a == 8'h2B) sh_mode = d[0];
  endfunction

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    shadow_write(a, d);
  endtask

  task automatic reg_read(logic [7:0] a, logic [7:0] exp, string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp, $sformatf("read 0x%0h", a));
    @(negedge clk);
  endtask

  // Drives one frame of nbits strobes; an optional register write rides with strobe wr_pos
  task automatic run_frame(int nbits, int gap_pct, int wr_pos,
                           logic [7:0] wa, logic [7:0] wd);
    for (int p = 0; p < nbits; p++) begin
      exp_t e;
      logic b_bp, b_rx;
      while ($urandom_range(99) < gap_pct) begin
        bit_stb = 1'b0; fsync = 1'b0; reg_we = 1'b0;
        @(negedge clk);
      end
      b_bp = 1'($urandom); b_rx = 1'($urandom);
      bit_stb = 1'b1; fsync = (p == 0); bp_data = b_bp; rx_data = b_rx;
      if (p % 8 == 0) begin
        lat_sel = sh_mask[p / 8]; lat_mode = sh_mode; lat_code = sh_code;
        mid_write = 1'b0;
      end
      if (!lat_sel)     begin e.val = b_bp;                 e.req = "R5"; end
      else if (lat_mode) begin e.val = b_rx;                e.req = "R6"; end
      else              begin e.val = lat_code[7 - p % 8];  e.req = "R4"; end
      if (mid_write) e.req = "R9";
      sb_q.push_back(e);
      if (p == wr_pos) begin
        reg_we = 1'b1; reg_addr = wa; reg_wdata = wd;
        shadow_write(wa, wd);
        mid_write = 1'b1;
      end else begin
        reg_we = 1'b0;
      end
      @(negedge clk);
    end
    bit_stb = 1'b0; fsync = 1'b0; reg_we = 1'b0;
  endtask

  // Monitor: each valid output bit is compared with the oldest expected bit
  always @(negedge clk) begin
    if (rst_n && !finished && tx_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8", 1, 0, "valid with nothing expected");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(tx_data === e.val, e.req, int'(tx_data), int'(e.val), "tx bit");
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL R8 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    check(tx_valid == 1'b0, "R10", tx_valid, 0, "tx_valid after reset");
    check(tx_data == 1'b0, "R10", tx_data, 0, "tx_data after reset");
    @(negedge clk);
    for (int a = 8'h26; a <= 8'h2B; a++) reg_read(8'(a), 8'h00, "R10");

    // R3: register access
    reg_write(8'h2A, 8'hA5); reg_read(8'h2A, 8'hA5, "R3");
    reg_write(8'h2B, 8'hFF); reg_read(8'h2B, 8'h01, "R3");
    reg_write(8'h25, 8'h77); reg_read(8'h25, 8'h00, "R3");
    reg_write(8'h30, 8'h77); reg_read(8'h30, 8'h00, "R3");
    reg_write(8'h28, 8'h3C); reg_read(8'h28, 8'h3C, "R3");
    reg_write(8'h28, 8'h00); reg_write(8'h2B, 8'h00);

    // R1, R5: everything passes through
    run_frame(256, 0, -1, 8'h00, 8'h00);
    // R2, R4: channels 1 and 32 only
    reg_write(8'h2A, 8'h96); reg_write(8'h26, 8'h01); reg_write(8'h29, 8'h80);
    run_frame(256, 0, -1, 8'h00, 8'h00);
    // R2, R8: scattered channels with gaps between strobes
    reg_write(8'h26, 8'h00); reg_write(8'h29, 8'h00);
    reg_write(8'h27, 8'h5A); reg_write(8'h28, 8'h81);
    run_frame(256, 30, -1, 8'h00, 8'h00);
    // R7: all channels idle
    for (int a = 8'h26; a <= 8'h29; a++) reg_write(8'(a), 8'hFF);
    reg_write(8'h2A, 8'h3C);
    run_frame(256, 10, -1, 8'h00, 8'h00);
    // R6, R7: all channels looped back
    reg_write(8'h2B, 8'h01);
    run_frame(256, 10, -1, 8'h00, 8'h00);
    // R6: partial loopback
    reg_write(8'h26, 8'h0F); reg_write(8'h27, 8'h00);
    reg_write(8'h28, 8'h00); reg_write(8'h29, 8'hF0);
    run_frame(256, 0, -1, 8'h00, 8'h00);
    // R9: mode flip inside channel 2 of a looped frame
    run_frame(256, 5, 10, 8'h2B, 8'h00);
    // R9: mask set inside channel 5 takes effect next frame
    reg_write(8'h26, 8'h00); reg_write(8'h29, 8'h00); reg_write(8'h2A, 8'hE1);
    run_frame(256, 0, 35, 8'h26, 8'h10);
    run_frame(256, 0, -1, 8'h00, 8'h00);
    // R1: early frame sync restarts the position
    reg_write(8'h27, 8'h0F);
    run_frame(100, 0, -1, 8'h00, 8'h00);
    run_frame(256, 0, -1, 8'h00, 8'h00);

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R8", sb_q.size(), 0, "outstanding bits");
    check(tx_valid == 1'b0, "R8", tx_valid, 0, "tx_valid when idle");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule